// File: doc/BRIEF.md
# Interruptible Block Memory Copy Engine

This block moves a run of bytes from one place in memory to another over a byte-wide memory port. To start it, give it a source pointer, a destination pointer, a byte count and a mode, then pulse the start strobe. It first reads memory once at the source address and once at the destination address. After that it copies one byte per read/write pair. Both pointers step up by one and the count steps down by one each time a byte is written.

There are two modes. In word mode the count is the full 16-bit value. In this mode the copy can be stopped between bytes by an unmasked maskable interrupt request or by the non-maskable request. When that happens the engine emits a one-cycle suspended pulse. The pointer and count outputs then hold exactly what is needed to carry on. Software restarts the engine with those values while the count is nonzero.

In byte mode only the low eight bits of the count are used, and every interrupt request is ignored until the copy has finished.

Top module: `blkcopy_engine`

## Requirements
- R1: After a start strobe is accepted while idle, the first memory access is a read at the source pointer and the second is a read at the destination pointer. The data returned by these two reads is discarded.
- R2: Each byte is read at the current source pointer and then written to the current destination pointer with the data that was read. After each write both pointers advance by one, modulo 2^24, and the count drops by one.
- R3: An uninterrupted copy of n bytes makes exactly 2n+2 memory accesses. Counting the cycle that presents the start strobe as cycle 1, done_o is high in cycle 2n+4. When n = 0, nothing is written.
- R4: In word mode (mode_word_i = 1) n is all 16 bits of cnt_i. In byte mode (mode_word_i = 0) n is cnt_i[7:0] and cnt_i[15:8] is ignored.
- R5: In word mode a request that can be honoured, seen during the write cycle of a byte that is not the last, ends the copy after that write. No further access follows. susp_o is high in cycle 2k+4 when k bytes were copied.
- R6: After a suspend, src_o and dst_o hold the next source and destination addresses and cnt_o holds the bytes still to move. Restarting with those values completes the copy correctly.
- R7: A maskable request (irq_i) is honoured only while irq_mask_i = 0. nmi_i is always honoured in word mode.
- R8: In byte mode no request, the non-maskable one included, ever suspends a copy.
- R9: A start strobe, and any change on the src_i, dst_i, cnt_i or mode_word_i inputs, has no effect while busy_o is high.
- R10: done_o and susp_o are single-cycle pulses and are never high together. A request during the last byte's write still ends the copy with done_o.
- R11: During and after reset the engine is idle: no memory request, busy_o, done_o and susp_o low, and the pointers and count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, taken only while idle |
| mode_word_i | input | 1 | 1 = interruptible 16-bit count mode, 0 = non-interruptible 8-bit count mode |
| src_i | input | 24 | Starting source address |
| dst_i | input | 24 | Starting destination address |
| cnt_i | input | 16 | Byte count |
| irq_i | input | 1 | Maskable interrupt request |
| irq_mask_i | input | 1 | 1 masks irq_i |
| nmi_i | input | 1 | Non-maskable interrupt request |
| mem_req_o | output | 1 | Memory access strobe, one cycle per access |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 24 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the cycle of the read strobe |
| src_o | output | 24 | Current source pointer |
| dst_o | output | 24 | Current destination pointer |
| cnt_o | output | 16 | Bytes still to copy |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle pulse on normal completion |
| susp_o | output | 1 | One-cycle pulse on an interrupt stop |

## Verification
The assertions check several rules on every cycle. A suspend always follows a write cycle and only happens in word mode. done and suspended are exclusive one-cycle pulses. Every write advances both pointers and decrements the count. The count reads zero at completion. A busy engine never re-enters its first read state.

Other behaviour can only be shown by the bench's scenarios, compared against a bench-side memory model. These include the exact completion cycle, the total number of accesses, the order of the two preliminary reads, and the copied memory contents. They also include the masking of the maskable request, the 8-bit count truncation in byte mode, pointer wrap, and a correct finish after a suspend and restart.

// File: rtl/blkcopy_pkg.sv
`timescale 1ns/1ps
package blkcopy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_SRC,
    ST_PRE_DST,
    ST_RD,
    ST_WR
  } blkcopy_st_e;
endpackage

// File: rtl/blkcopy_dp.sv
`timescale 1ns/1ps
module blkcopy_dp #(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int BYTE_CNT_W = 8,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              cap_i,
  input  logic              mode_word_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] data_q
);
  logic [ADDR_W-1:0] src_d, dst_d;
  logic [CNT_W-1:0]  cnt_d, cnt_load;
  logic              ptr_en;

  assign cnt_load = mode_word_i ? cnt_i : CNT_W'(cnt_i[BYTE_CNT_W-1:0]);
  assign ptr_en   = load_i | step_i;

  always_comb begin
    if (load_i) begin
      src_d = src_i;
      dst_d = dst_i;
      cnt_d = cnt_load;
    end else begin
      src_d = src_q + ADDR_W'(1);
      dst_d = dst_q + ADDR_W'(1);
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (cap_i) data_q <= rdata_i;
  end

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (src_q == $past(src_q) + ADDR_W'(1)) && (dst_q == $past(dst_q) + ADDR_W'(1))
               && (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2
endmodule

// File: rtl/blkcopy_ctrl.sv
`timescale 1ns/1ps
module blkcopy_ctrl
  import blkcopy_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        mode_word_i,
  input  logic        cnt_zero_i,
  input  logic        last_i,
  input  logic        irq_i,
  input  logic        irq_mask_i,
  input  logic        nmi_i,
  output blkcopy_st_e st_q,
  output logic        load_o,
  output logic        step_o,
  output logic        cap_o,
  output logic        done_q,
  output logic        susp_q
);
  blkcopy_st_e st_d;
  logic        mode_q, mode_d;
  logic        done_d, susp_d;
  logic        take;

  assign take   = mode_q & (nmi_i | (irq_i & ~irq_mask_i));
  assign load_o = (st_q == ST_IDLE) && start_i;
  assign step_o = (st_q == ST_WR);
  assign cap_o  = (st_q == ST_RD);

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    done_d = 1'b0;
    susp_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_PRE_SRC;
          mode_d = mode_word_i;
        end
      end
      ST_PRE_SRC: st_d = ST_PRE_DST;
      ST_PRE_DST: begin
        if (cnt_zero_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_RD;
        end
      end
      ST_RD: st_d = ST_WR;
      ST_WR: begin
        if (last_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else if (take) begin
          st_d   = ST_IDLE;
          susp_d = 1'b1;
        end else begin
          st_d = ST_RD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      done_q <= done_d;
      susp_q <= susp_d;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, susp_q})); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_SUSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |=> !susp_q); // R10
  AST_BYTE_MODE_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> mode_q); // R8
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> (st_q != ST_PRE_SRC)); // R9
endmodule

// File: rtl/blkcopy_engine.sv
`timescale 1ns/1ps
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int BYTE_CNT_W = 8,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_word_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_i,
  input  logic              irq_mask_i,
  input  logic              nmi_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              susp_o
);
  logic [1:0]  rst_pipe;
  logic        rst_int_n;
  blkcopy_st_e st;
  logic        load, step, cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  blkcopy_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .mode_word_i(mode_word_i),
    .cnt_zero_i (cnt_o == '0),
    .last_i     (cnt_o == CNT_W'(1)),
    .irq_i      (irq_i),
    .irq_mask_i (irq_mask_i),
    .nmi_i      (nmi_i),
    .st_q       (st),
    .load_o     (load),
    .step_o     (step),
    .cap_o      (cap),
    .done_q     (done_o),
    .susp_q     (susp_o)
  );

  blkcopy_dp #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .BYTE_CNT_W(BYTE_CNT_W),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (load),
    .step_i     (step),
    .cap_i      (cap),
    .mode_word_i(mode_word_i),
    .src_i      (src_i),
    .dst_i      (dst_i),
    .cnt_i      (cnt_i),
    .rdata_i    (mem_rdata_i),
    .src_q      (src_o),
    .dst_q      (dst_o),
    .cnt_q      (cnt_o),
    .data_q     (mem_wdata_o)
  );

  assign busy_o     = (st != ST_IDLE);
  assign mem_req_o  = busy_o;
  assign mem_we_o   = (st == ST_WR);
  assign mem_addr_o = ((st == ST_PRE_SRC) || (st == ST_RD)) ? src_o : dst_o;

  AST_SUSP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    susp_o |-> $past(mem_we_o)); // R5
  AST_DONE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (cnt_o == '0)); // R3
  AST_IDLE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o || susp_o) |-> !mem_req_o); // R5
endmodule

// File: tb/test_blkcopy_engine.sv
`timescale 1ns/1ps
module test_blkcopy_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, mode_word, irq, irq_mask, nmi;
  logic [23:0] src, dst;
  logic [15:0] cnt;
  logic        mem_req, mem_we, busy, done, susp;
  logic [23:0] mem_addr, src_o, dst_o;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] cnt_o;

  always #2.5 clk = ~clk;

  blkcopy_engine i_blkcopy_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_word_i(mode_word),
    .src_i(src), .dst_i(dst), .cnt_i(cnt), .irq_i(irq), .irq_mask_i(irq_mask),
    .nmi_i(nmi), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .src_o(src_o), .dst_o(dst_o),
    .cnt_o(cnt_o), .busy_o(busy), .done_o(done), .susp_o(susp)
  );

  logic [7:0]  mem     [0:1023];
  logic [7:0]  exp_mem [0:1023];
  logic [23:0] addr_log[0:4095];
  int          acc_cnt = 0, wr_cnt = 0, wr0 = 0, irq_k = 0, irq_kind = 0;
  logic        irq_on = 1'b0, fill_now = 1'b0;
  int          checks = 0, errors = 0, cycles = 0;

  function automatic logic [7:0] fill_val(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  assign mem_rdata = mem[mem_addr[9:0]];
  assign irq       = irq_on && (irq_kind == 1 || irq_kind == 2) && (wr_cnt - wr0 == irq_k - 1);
  assign irq_mask  = (irq_kind == 2);
  assign nmi       = irq_on && (irq_kind == 3) && (wr_cnt - wr0 == irq_k - 1);

  always @(posedge clk) begin
    if (fill_now) begin
      for (int i = 0; i < 1024; i++) mem[i] <= fill_val(i);
    end else if (mem_req && mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
    end
    if (mem_req) begin
      addr_log[acc_cnt % 4096] <= mem_addr;
      acc_cnt <= acc_cnt + 1;
    end
    if (mem_req && mem_we) wr_cnt <= wr_cnt + 1;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // kind: 0 none, 1 maskable unmasked, 2 maskable masked, 3 non-maskable; k = byte during whose write it is raised
  task automatic do_copy(input logic [23:0] s, input logic [23:0] d, input logic [15:0] c,
                         input bit word, input int kind, input int k, input bit poke, input string req);
    int  n_eff, m, edges, acc0, bad;
    bit  take;
    n_eff = word ? int'(c) : int'(c[7:0]);
    take  = word && (kind == 1 || kind == 3) && k >= 1 && k < n_eff;
    m     = take ? k : n_eff;
    @(negedge clk);
    src = s; dst = d; cnt = c; mode_word = word;
    acc0 = acc_cnt; wr0 = wr_cnt; irq_kind = kind; irq_k = k; irq_on = (kind != 0);
    start = 1'b1;
    @(posedge clk); edges = 1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      src = ~s; dst = ~d; cnt = ~c; mode_word = ~word;
    end
    while (!(done || susp) && edges < 4000) begin
      start = (poke && edges == 3);
      @(posedge clk); edges++;
      @(negedge clk);
    end
    start = 1'b0; irq_on = 1'b0;
    chk(take ? "R5" : "R3", "cycle of end pulse", edges + 1, 2 * m + 4);
    chk(req, "done pulse", done, !take);
    chk(take ? "R7" : "R8", "suspend pulse", susp, take);
    chk("R3", "access count", acc_cnt - acc0, 2 * m + 2);
    chk("R1", "first access addr", addr_log[acc0 % 4096], s);
    chk("R1", "second access addr", addr_log[(acc0 + 1) % 4096], d);
    chk("R6", "src pointer", src_o, 24'(s + 24'(m)));
    chk("R6", "dst pointer", dst_o, 24'(d + 24'(m)));
    chk("R6", "count left", cnt_o, n_eff - m);
    for (int i = 0; i < m; i++) exp_mem[10'(d + 24'(i))] = exp_mem[10'(s + 24'(i))];
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk("R2", "memory mismatches", bad, 0);
    @(posedge clk); @(negedge clk);
    chk("R10", "pulse cleared and idle", {done, susp, busy, mem_req}, 0);
  endtask

  initial begin
    logic [23:0] rs, rd;
    logic [15:0] rc;
    bit rw;
    int rk, rkind;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; mode_word = 1'b0;
    src = '0; dst = '0; cnt = '0;
    repeat (3) @(negedge clk);
    chk("R11", "reset outputs", {mem_req, busy, done, susp, src_o, dst_o, cnt_o}, 0);
    rst_n = 1'b1;
    fill_now = 1'b1;
    @(negedge clk); fill_now = 1'b0;
    for (int i = 0; i < 1024; i++) exp_mem[i] = fill_val(i);
    repeat (3) @(negedge clk);
    chk("R11", "idle after reset release", {mem_req, busy, done, susp}, 0);

    do_copy(24'h000010, 24'h000210, 16'd0,   1'b1, 0, 0, 1'b0, "R3");
    do_copy(24'h000020, 24'h000220, 16'd1,   1'b1, 0, 0, 1'b0, "R3");
    do_copy(24'h000030, 24'h000240, 16'd40,  1'b1, 0, 0, 1'b1, "R9");
    do_copy(24'h000000, 24'h000200, 16'h0100, 1'b0, 0, 0, 1'b0, "R4");
    do_copy(24'h000000, 24'h000200, 16'h0100, 1'b1, 0, 0, 1'b0, "R4");
    do_copy(24'hFFFFF0, 24'h000300, 16'd32,  1'b1, 0, 0, 1'b0, "R2");
    do_copy(24'h000050, 24'h000250, 16'd20,  1'b1, 2, 4, 1'b0, "R7");
    do_copy(24'h000060, 24'h000260, 16'h7F20, 1'b0, 3, 3, 1'b0, "R8");
    do_copy(24'h000070, 24'h000270, 16'd20,  1'b1, 1, 20, 1'b0, "R10");
    do_copy(24'h000080, 24'h000280, 16'd20,  1'b1, 3, 5, 1'b0, "R5");
    do_copy(src_o, dst_o, cnt_o, 1'b1, 0, 0, 1'b0, "R6");
    do_copy(24'h000090, 24'h000290, 16'd12,  1'b1, 1, 1, 1'b0, "R7");
    do_copy(src_o, dst_o, cnt_o, 1'b1, 1, 4, 1'b0, "R6");
    do_copy(src_o, dst_o, cnt_o, 1'b1, 0, 0, 1'b0, "R6");

    for (int r = 0; r < 30; r++) begin
      rs    = 24'($urandom_range(0, 255));
      rd    = 24'(512 + $urandom_range(0, 255));
      rw    = 1'($urandom_range(0, 1));
      rc    = rw ? 16'($urandom_range(0, 255)) : 16'($urandom);
      rkind = $urandom_range(0, 3);
      rk    = $urandom_range(1, 40);
      do_copy(rs, rd, rc, rw, rkind, rk, 1'($urandom_range(0, 1)) && (rc[7:0] > 2) && !rw, "R2");
    end

    summary();
    $finish;
  end
endmodule